// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port behind a small memory-mapped register bus. Software drives pin levels through an output data register and chooses which pins are driven through an output-enable register. A read-only input register shows the synchronised pin levels whichever way each pin is set.

Each pin can watch for one of four trigger conditions: rising edge, falling edge, high level or low level. A routing mask decides which pins may record their condition in a sticky status register. A separate enable mask decides which status bits reach the single interrupt line for the port. Every writable register answers at three word addresses. One replaces the whole value, one sets the bits written as 1, and one clears the bits written as 1. Software can therefore change single pins without a read-modify-write.

Top module: `gpio_irq_port`

## Requirements
- R1: The word address splits into a register select in bits [4:2] and an alias in bits [1:0]. Alias 0 writes the whole register, alias 1 ORs the data in, and alias 2 clears the bits that are 1 in the data. The selects are: 0 output data, 1 input data (read only), 2 output enable, 3 routing, 4 interrupt enable, 5 level-mode, 6 polarity, 7 status.
- R2: `pin_out` equals the output data register and `pin_oe` equals the output-enable register, where a 1 marks the pin as driven.
- R3: Reading the input data register returns `pin_in` after a two-flop synchroniser, whatever the output enables hold.
- R4: The trigger type of pin i is {polarity[i], level-mode[i]}: 00 falling edge, 01 low level, 10 rising edge, 11 high level. Edges are found by comparing the synchronised level with its value one cycle earlier.
- R5: A status bit is set only when its pin's condition is present and its routing bit is 1.
- R6: Status bits are cleared only by the clear alias of the status register. Whole writes and set-alias writes to the status register have no effect.
- R7: `irq` is high exactly when some status bit and its interrupt-enable bit are both 1.
- R8: In a level mode, a status bit that is cleared while its level is still present is set again on the following cycle.
- R9: When a detected condition and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R10: After reset every register is 0, `pin_out`, `pin_oe` and `irq` are 0, and the read data is 0.
- R11: Read data appears on `bus_rdata` one clock after the read is presented, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Word address: select [4:2], alias [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enables to the pads |
| irq | output | 1 | Combined port interrupt |

## Verification
The hardest case to reach from the ports is a clear write to a status bit that lands in the same cycle as a new edge on that pin (R9). The bench gets there by counting registers. It changes the pin on a falling clock edge, waits two rising edges while the level passes the synchroniser, and then presents the clear so that it is captured on the same rising edge that records the edge. The trigger sweep covers all four modes on both end pins and one middle pin, with every pair of before and after levels. The expected status and interrupt values are computed in the bench from the mode bits and the two levels.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   typedef enum logic [1:0] {
      ALIAS_WR   = 2'd0,
      ALIAS_SET  = 2'd1,
      ALIAS_CLR  = 2'd2,
      ALIAS_NONE = 2'd3
   } alias_e;

   typedef enum logic [2:0] {
      SEL_DOUT  = 3'd0,
      SEL_DIN   = 3'd1,
      SEL_DOE   = 3'd2,
      SEL_ROUTE = 3'd3,
      SEL_IEN   = 3'd4,
      SEL_LEVEL = 3'd5,
      SEL_POL   = 3'd6,
      SEL_STAT  = 3'd7
   } sel_e;

   localparam int NUM_CTL = 6;

   function automatic sel_e ctl_sel(input int idx);
      case (idx)
         0:       return SEL_DOUT;
         1:       return SEL_DOE;
         2:       return SEL_ROUTE;
         3:       return SEL_IEN;
         4:       return SEL_LEVEL;
         default: return SEL_POL;
      endcase
   endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stage[k] <= '0;
      end else begin
         stage[0] <= d;
         for (int k = 1; k < STAGES; k++) stage[k] <= stage[k-1];
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_ctl_reg.sv
module gpio_ctl_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_we,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (wr_we)  q <= wdata;
      else if (set_we) q <= q | wdata;
      else if (clr_we) q <= q & ~wdata;
   end

   AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((q & $past(wdata)) == $past(wdata))); // R1
   AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((q & $past(wdata)) == '0)); // R1
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_sync,
   input  logic [W-1:0] route,
   input  logic [W-1:0] level_mode,
   input  logic [W-1:0] polarity,
   input  logic         clr_we,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] status
);
   logic [W-1:0] lvl_prev;
   logic [W-1:0] cond;

   for (genvar i = 0; i < W; i++) begin : g_pin
      assign cond[i] = level_mode[i] ? (lvl_sync[i] ~^ polarity[i])
                     : polarity[i]   ? (lvl_sync[i] & ~lvl_prev[i])
                                     : (~lvl_sync[i] & lvl_prev[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_prev <= '0;
         status   <= '0;
      end else begin
         lvl_prev <= lvl_sync;
         status   <= (clr_we ? (status & ~clr_mask) : status) | (cond & route);
      end
   end

   AST_STAT_ONLY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(status) & ~status)) |-> $past(clr_we)); // R6
   AST_STAT_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status & ~$past(status))) |-> (|(status & ~$past(status) & $past(route)))); // R5
   AST_LEVEL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (|(level_mode & route & (lvl_sync ~^ polarity))) |=> (|status)); // R8
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_we,
   input  logic [4:0]       bus_addr,
   input  logic [NPINS-1:0] bus_wdata,
   output logic [NPINS-1:0] bus_rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   output logic             irq
);
   if (NPINS < 1 || NPINS > 32) begin : g_bad_width
      $error("gpio_irq_port: NPINS must lie in 1..32");
   end

   localparam int SYNC_STAGES = 2;

   sel_e   acc_sel;
   alias_e acc_alias;
   logic   acc_wr;
   logic   acc_rd;

   assign acc_sel   = sel_e'(bus_addr[4:2]);
   assign acc_alias = alias_e'(bus_addr[1:0]);
   assign acc_wr    = bus_sel & bus_we;
   assign acc_rd    = bus_sel & ~bus_we;

   logic [NPINS-1:0] ctl_q [NUM_CTL];

   for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
      logic hit;
      assign hit = acc_wr && (acc_sel == ctl_sel(g));
      gpio_ctl_reg #(.W(NPINS)) u_reg (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_we  (hit && acc_alias == ALIAS_WR),
         .set_we (hit && acc_alias == ALIAS_SET),
         .clr_we (hit && acc_alias == ALIAS_CLR),
         .wdata  (bus_wdata),
         .q      (ctl_q[g])
      );
   end

   logic [NPINS-1:0] dout_q, doe_q, route_q, ien_q, level_q, pol_q;
   assign dout_q  = ctl_q[0];
   assign doe_q   = ctl_q[1];
   assign route_q = ctl_q[2];
   assign ien_q   = ctl_q[3];
   assign level_q = ctl_q[4];
   assign pol_q   = ctl_q[5];

   logic [NPINS-1:0] din_sync;
   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (din_sync)
   );

   logic             stat_clr;
   logic [NPINS-1:0] status_q;
   assign stat_clr = acc_wr && acc_sel == SEL_STAT && acc_alias == ALIAS_CLR;

   gpio_irq_detect #(.W(NPINS)) u_detect (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_sync   (din_sync),
      .route      (route_q),
      .level_mode (level_q),
      .polarity   (pol_q),
      .clr_we     (stat_clr),
      .clr_mask   (bus_wdata),
      .status     (status_q)
   );

   logic [NPINS-1:0] rd_mux;
   always_comb begin
      case (acc_sel)
         SEL_DOUT:  rd_mux = dout_q;
         SEL_DIN:   rd_mux = din_sync;
         SEL_DOE:   rd_mux = doe_q;
         SEL_ROUTE: rd_mux = route_q;
         SEL_IEN:   rd_mux = ien_q;
         SEL_LEVEL: rd_mux = level_q;
         SEL_POL:   rd_mux = pol_q;
         default:   rd_mux = status_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (acc_rd) bus_rdata <= rd_mux;
   end

   assign pin_out = dout_q;
   assign pin_oe  = doe_q;
   assign irq     = |(status_q & ien_q);

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|ien_q)); // R7
   AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(acc_rd) |-> $stable(bus_rdata)); // R11
endmodule

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;
   logic        irq;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   gpio_irq_port u_gpio_irq_port (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   localparam logic [2:0] S_DOUT = 3'd0, S_DIN = 3'd1, S_DOE = 3'd2, S_ROUTE = 3'd3,
                          S_IEN = 3'd4, S_LEVEL = 3'd5, S_POL = 3'd6, S_STAT = 3'd7;
   localparam logic [1:0] A_WR = 2'd0, A_SET = 2'd1, A_CLR = 2'd2;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [1:0] al, input logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = {sel, al}; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] sel, output logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = {sel, A_WR};
      @(posedge clk); @(negedge clk);
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      chk("R10 pin_out", pin_out, 32'h0);
      chk("R10 pin_oe", pin_oe, 32'h0);
      chk("R10 irq", {31'h0, irq}, 32'h0);
      chk("R10 rdata", bus_rdata, 32'h0);
      rd(S_STAT, v); chk("R10 status", v, 32'h0);
      rd(S_ROUTE, v); chk("R10 route", v, 32'h0);

      // R1 R2 R11 aliases on output data and enable
      wr(S_DOUT, A_WR, 32'hA5A5_0F0F);
      wr(S_DOUT, A_SET, 32'h0000_F000);
      wr(S_DOUT, A_CLR, 32'h0000_000F);
      chk("R2 pin_out", pin_out, 32'hA5A5_FF00);
      rd(S_DOUT, v); chk("R1 R11 dout readback", v, 32'hA5A5_FF00);
      idle(2); chk("R11 rdata holds", bus_rdata, 32'hA5A5_FF00);
      wr(S_DOE, A_SET, 32'h8000_0001);
      wr(S_DOE, A_SET, 32'h0000_0100);
      wr(S_DOE, A_CLR, 32'h0000_0001);
      chk("R2 R1 pin_oe", pin_oe, 32'h8000_0100);

      // R3 input register, independent of enables
      pin_in = 32'h1234_5678;
      idle(1);
      rd(S_DIN, v); chk("R3 din two-flop not yet", v, 32'h0);
      rd(S_DIN, v); chk("R3 din after sync", v, 32'h1234_5678);
      wr(S_DOE, A_WR, 32'h0);
      wr(S_DOUT, A_WR, 32'h0);
      pin_in = 32'h0;
      idle(4);

      // R6 status ignores whole and set writes
      wr(S_STAT, A_WR, 32'hFFFF_FFFF);
      wr(S_STAT, A_SET, 32'hFFFF_FFFF);
      rd(S_STAT, v); chk("R6 status ignores writes", v, 32'h0);

      // R4 R5 R7 trigger sweep
      for (int m = 0; m < 4; m++) begin
         for (int pi = 0; pi < 3; pi++) begin
            for (int ab = 0; ab < 4; ab++) begin
               int p;
               logic a, b, lvl, pol, exp_s, en;
               p = (pi == 0) ? 0 : (pi == 1) ? 9 : 31;
               lvl = m[0]; pol = m[1];
               a = ab[1]; b = ab[0];
               en = ab[0] ^ pi[0];
               wr(S_ROUTE, A_WR, 32'h0);
               wr(S_IEN, A_WR, 32'h0);
               pin_in = '0; pin_in[p] = a;
               wr(S_LEVEL, A_WR, lvl ? (32'h1 << p) : 32'h0);
               wr(S_POL, A_WR, pol ? (32'h1 << p) : 32'h0);
               idle(4);
               wr(S_ROUTE, A_WR, 32'h1 << p);
               wr(S_STAT, A_CLR, 32'hFFFF_FFFF);
               idle(1);
               pin_in[p] = b;
               idle(4);
               if (lvl) exp_s = (a == pol) || (b == pol);
               else     exp_s = (a != b) && (b == pol);
               rd(S_STAT, v);
               chk($sformatf("R4 R5 mode%0d pin%0d %0d->%0d", m, p, a, b), v,
                   exp_s ? (32'h1 << p) : 32'h0);
               if (en) wr(S_IEN, A_SET, 32'h1 << p);
               chk($sformatf("R7 irq mode%0d pin%0d", m, p), {31'h0, irq},
                   {31'h0, exp_s & en});
            end
         end
      end

      // R5 edge on an unrouted pin leaves status clear
      wr(S_ROUTE, A_WR, 32'h0);
      wr(S_IEN, A_WR, 32'hFFFF_FFFF);
      wr(S_LEVEL, A_WR, 32'h0);
      wr(S_POL, A_WR, 32'hFFFF_FFFF);
      pin_in = 32'h0; idle(4);
      wr(S_STAT, A_CLR, 32'hFFFF_FFFF);
      pin_in = 32'h0000_00F0; idle(4);
      rd(S_STAT, v); chk("R5 unrouted", v, 32'h0);
      chk("R7 irq low when no status", {31'h0, irq}, 32'h0);

      // R8 level condition sets again after clear
      wr(S_LEVEL, A_WR, 32'h0000_0020);
      wr(S_ROUTE, A_WR, 32'h0000_0020);
      idle(2);
      wr(S_STAT, A_CLR, 32'h0000_0020);
      rd(S_STAT, v); chk("R8 level re-set", v, 32'h0000_0020);
      pin_in = 32'h0; idle(4);
      wr(S_STAT, A_CLR, 32'hFFFF_FFFF);
      rd(S_STAT, v); chk("R8 level gone stays clear", v, 32'h0);

      // R9 event and clear in the same cycle: event wins
      wr(S_LEVEL, A_WR, 32'h0);
      wr(S_ROUTE, A_WR, 32'h0000_0008);
      idle(4);
      wr(S_STAT, A_CLR, 32'hFFFF_FFFF);
      pin_in[3] = 1'b1;
      idle(2);
      wr(S_STAT, A_CLR, 32'h0000_0008);
      rd(S_STAT, v); chk("R9 event beats clear", v, 32'h0000_0008);
      wr(S_STAT, A_CLR, 32'h0000_0008);
      rd(S_STAT, v); chk("R6 clear alias clears", v, 32'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule